// File: doc/BRIEF.md
# Switch-on-Miss Thread Context Controller

This controller lets one pipeline share its issue slots among a small set of hardware thread contexts, with up to four threads. One thread keeps issuing until the pipeline reports that this thread has hit a long-latency event, such as a cache miss. The controller then marks that thread as waiting, stores the PC of the instruction that missed, and asks the pipeline to flush that thread's in-flight work. It holds issue stalled for a fixed switch penalty and then hands the pipeline to the next thread that is ready.

Miss-return notices make waiting threads eligible again. A resumed thread starts from its stored PC, so the instruction that missed is executed again. If no thread is ready when the penalty ends, the stall is held until a return arrives. The pipeline reads the active thread ID and that thread's PC. While the pipeline is issuing, it reports each new PC of the running thread.

Top module: `mt_ctx_ctrl`

## Requirements
- R1: After reset the active thread is 0, `issue_stall` and `flush_req` are low, and `active_pc` is the boot PC of thread 0. Thread i boots at `BOOT_BASE + i*BOOT_STRIDE`, which gives 0x000, 0x100, 0x200 and 0x300 by default.
- R2: While issue is not stalled, a pulse on `adv_valid` writes `adv_pc` into the active thread's PC, and `active_pc` shows it on the next cycle. A pulse while stalled has no effect.
- R3: A miss that is accepted raises `flush_req` for exactly the one cycle after the miss is sampled. `issue_stall` is high for exactly `PENALTY` cycles (3 by default), starting that same cycle, when another thread is ready at the end of the penalty.
- R4: A miss is ignored if `miss_tid` is not the active thread, or if it arrives while issue is stalled. An ignored miss causes no flush, no stall and no PC change.
- R5: When the penalty ends, the next thread is the first ready one in round-robin order, starting with the thread after the one that missed and wrapping around. Waiting threads are skipped.
- R6: A resumed thread's `active_pc` is the PC of the instruction that missed. A thread that has never run resumes at its boot PC.
- R7: If no thread is ready when the penalty ends, `issue_stall` stays high. A return sampled in a later cycle resumes the returned thread on the next cycle.
- R8: A return for thread k clears its waiting state in the same cycle it is sampled, so k can be chosen at a selection made in that same cycle.
- R9: `active_tid` changes only in the cycle in which `issue_stall` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_valid | input | 1 | Running thread reports a new PC |
| adv_pc | input | PC_W | New PC of the running thread |
| miss_valid | input | 1 | Long-latency event reported |
| miss_tid | input | TID_W | Thread that hit the event |
| miss_pc | input | PC_W | PC of the instruction that missed |
| ret_valid | input | 1 | A pending miss has returned |
| ret_tid | input | TID_W | Thread whose miss returned |
| active_tid | output | TID_W | Thread that owns the pipeline |
| active_pc | output | PC_W | PC of the active thread |
| issue_stall | output | 1 | Issue halted (switch penalty or no ready thread) |
| flush_req | output | 1 | Flush in-flight work of the thread that missed |

## Verification
A miss from the running thread checks the flush pulse and the penalty length, then checks the handover to a thread that has never run. A chain of misses across all four threads, with one return arriving in between, shows that waiting threads are skipped and that a thread resumes at the PC of the instruction that missed. Misses with a wrong thread ID, and misses or PC writes during a switch, separate "ignored" from "accepted". A return timed to the exact selection cycle, and a case where every thread is waiting, separate same-cycle eligibility from the held-stall path.

// File: rtl/mt_ctx_pkg.sv
package mt_ctx_pkg;
    typedef enum logic [1:0] {
        SW_RUN  = 2'd0,
        SW_SWAP = 2'd1,
        SW_IDLE = 2'd2
    } sw_state_e;

    // Returns (base + step) wrapped into [0, n)
    function automatic int wrap_add(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction
endpackage

// File: rtl/ctx_pc_bank.sv
module ctx_pc_bank #(
    parameter int NT          = 4,
    parameter int PC_W        = 32,
    parameter int TID_W       = 2,
    parameter int BOOT_BASE   = 0,
    parameter int BOOT_STRIDE = 'h100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_tid,
    input  logic [PC_W-1:0]  wr_val,
    input  logic [TID_W-1:0] rd_tid,
    output logic [PC_W-1:0]  rd_val
);
    logic [PC_W-1:0] pc_q [NT];

    for (genvar g = 0; g < NT; g++) begin : g_ctx
        localparam logic [PC_W-1:0] BOOT_PC = PC_W'(BOOT_BASE + g * BOOT_STRIDE);
        always_ff @(posedge clk) begin
            if (rst)
                pc_q[g] <= BOOT_PC;
            else if (wr_en && (wr_tid == TID_W'(g)))
                pc_q[g] <= wr_val;
        end
    end

    assign rd_val = pc_q[rd_tid];
endmodule

// File: rtl/ctx_wait_tracker.sv
module ctx_wait_tracker #(
    parameter int NT    = 4,
    parameter int TID_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [TID_W-1:0] set_tid,
    input  logic             clr_en,
    input  logic [TID_W-1:0] clr_tid,
    output logic [NT-1:0]    ready_vec
);
    logic [NT-1:0] waiting_q;
    logic [NT-1:0] set_mask;
    logic [NT-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (set_en) set_mask[set_tid] = 1'b1;
        if (clr_en) clr_mask[clr_tid] = 1'b1;
    end

    // Return counts immediately for any selection made this cycle
    assign ready_vec = ~(waiting_q & ~clr_mask);

    always_ff @(posedge clk) begin
        if (rst)
            waiting_q <= '0;
        else
            waiting_q <= (waiting_q & ~clr_mask) | set_mask;
    end
endmodule

// File: rtl/ctx_switch_fsm.sv
module ctx_switch_fsm
    import mt_ctx_pkg::*;
#(
    parameter int NT      = 4,
    parameter int TID_W   = 2,
    parameter int PENALTY = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             miss_hit,
    input  logic [NT-1:0]    ready_vec,
    output logic [TID_W-1:0] active_tid,
    output logic             running,
    output logic             flush_req
);
    localparam int CNT_W = $clog2(PENALTY + 1);

    sw_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TID_W-1:0] tid_q;
    logic             flush_q;
    logic             pick_found;
    logic [TID_W-1:0] pick_tid;

    always_comb begin
        pick_found = 1'b0;
        pick_tid   = tid_q;
        for (int k = 1; k <= NT; k++) begin
            int idx;
            idx = wrap_add(int'(tid_q), k, NT);
            if (!pick_found && ready_vec[idx]) begin
                pick_found = 1'b1;
                pick_tid   = TID_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_RUN;
            cnt_q   <= '0;
            tid_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            unique case (state_q)
                SW_RUN: begin
                    if (miss_hit) begin
                        state_q <= SW_SWAP;
                        cnt_q   <= CNT_W'(PENALTY - 1);
                        flush_q <= 1'b1;
                    end
                end
                SW_SWAP: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - 1'b1;
                    end else if (pick_found) begin
                        tid_q   <= pick_tid;
                        state_q <= SW_RUN;
                    end else begin
                        state_q <= SW_IDLE;
                    end
                end
                SW_IDLE: begin
                    if (pick_found) begin
                        tid_q   <= pick_tid;
                        state_q <= SW_RUN;
                    end
                end
                default: state_q <= SW_RUN;
            endcase
        end
    end

    assign active_tid = tid_q;
    assign running    = (state_q == SW_RUN);
    assign flush_req  = flush_q;
endmodule

// File: rtl/mt_ctx_ctrl.sv
module mt_ctx_ctrl #(
    parameter int NT          = 4,
    parameter int PC_W        = 32,
    parameter int PENALTY     = 3,
    parameter int BOOT_BASE   = 0,
    parameter int BOOT_STRIDE = 'h100,
    localparam int TID_W      = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_valid,
    input  logic [PC_W-1:0]  adv_pc,
    input  logic             miss_valid,
    input  logic [TID_W-1:0] miss_tid,
    input  logic [PC_W-1:0]  miss_pc,
    input  logic             ret_valid,
    input  logic [TID_W-1:0] ret_tid,
    output logic [TID_W-1:0] active_tid,
    output logic [PC_W-1:0]  active_pc,
    output logic             issue_stall,
    output logic             flush_req
);
    logic          running;
    logic          miss_hit;
    logic          pc_wr;
    logic [PC_W-1:0] pc_wr_val;
    logic [NT-1:0] ready_vec;

    assign miss_hit  = running && miss_valid && (miss_tid == active_tid);
    assign pc_wr     = miss_hit || (running && adv_valid);
    assign pc_wr_val = miss_hit ? miss_pc : adv_pc;

    ctx_pc_bank #(
        .NT(NT), .PC_W(PC_W), .TID_W(TID_W),
        .BOOT_BASE(BOOT_BASE), .BOOT_STRIDE(BOOT_STRIDE)
    ) u_pc_bank (
        .clk(clk), .rst(rst),
        .wr_en(pc_wr), .wr_tid(active_tid), .wr_val(pc_wr_val),
        .rd_tid(active_tid), .rd_val(active_pc)
    );

    ctx_wait_tracker #(.NT(NT), .TID_W(TID_W)) u_wait (
        .clk(clk), .rst(rst),
        .set_en(miss_hit), .set_tid(active_tid),
        .clr_en(ret_valid), .clr_tid(ret_tid),
        .ready_vec(ready_vec)
    );

    ctx_switch_fsm #(.NT(NT), .TID_W(TID_W), .PENALTY(PENALTY)) u_fsm (
        .clk(clk), .rst(rst),
        .miss_hit(miss_hit), .ready_vec(ready_vec),
        .active_tid(active_tid), .running(running), .flush_req(flush_req)
    );

    assign issue_stall = !running;
endmodule

// File: rtl/mt_ctx_ctrl_chk.sv
module mt_ctx_ctrl_chk #(
    parameter int PENALTY = 3,
    parameter int TID_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [TID_W-1:0] active_tid,
    input logic             issue_stall,
    input logic             flush_req
);
    logic [7:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (issue_stall)
            run_len <= (run_len == 8'hff) ? run_len : run_len + 8'd1;
        else
            run_len <= '0;
    end

    assert_flush_single_R3: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);

    assert_flush_in_stall_R3: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> issue_stall);

    assert_stall_opens_with_flush_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(issue_stall) |-> flush_req);

    assert_stall_min_len_R3: assert property (@(posedge clk) disable iff (rst)
        (!issue_stall && run_len != 0) |-> (run_len >= 8'(PENALTY)));

    assert_tid_moves_at_resume_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_tid) |-> $fell(issue_stall));
endmodule

bind mt_ctx_ctrl mt_ctx_ctrl_chk #(.PENALTY(PENALTY), .TID_W(TID_W)) u_chk (
    .clk(clk), .rst(rst), .active_tid(active_tid),
    .issue_stall(issue_stall), .flush_req(flush_req)
);

// File: tb/mt_ctx_ctrl_bench.sv
module mt_ctx_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_valid = 1'b0;
    logic [31:0] adv_pc = '0;
    logic        miss_valid = 1'b0;
    logic [1:0]  miss_tid = '0;
    logic [31:0] miss_pc = '0;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_tid = '0;
    logic [1:0]  active_tid;
    logic [31:0] active_pc;
    logic        issue_stall;
    logic        flush_req;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    mt_ctx_ctrl u_mt_ctx_ctrl (
        .clk(clk), .rst(rst),
        .adv_valid(adv_valid), .adv_pc(adv_pc),
        .miss_valid(miss_valid), .miss_tid(miss_tid), .miss_pc(miss_pc),
        .ret_valid(ret_valid), .ret_tid(ret_tid),
        .active_tid(active_tid), .active_pc(active_pc),
        .issue_stall(issue_stall), .flush_req(flush_req)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        adv_valid  = 1'b0;
        miss_valid = 1'b0;
        ret_valid  = 1'b0;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic [1:0] tid, input logic [31:0] pc, input logic st, input logic fl);
        chk(req, "active_tid", 32'(active_tid), 32'(tid));
        chk(req, "active_pc", active_pc, pc);
        chk(req, "issue_stall", 32'(issue_stall), 32'(st));
        chk(req, "flush_req", 32'(flush_req), 32'(fl));
    endtask

    task automatic do_miss(input logic [1:0] tid, input logic [31:0] pc);
        miss_valid = 1'b1; miss_tid = tid; miss_pc = pc;
        tick();
    endtask

    task automatic test_reset();
        chk_state("R1", 2'd0, 32'h000, 1'b0, 1'b0);
    endtask

    task automatic test_adv();
        adv_valid = 1'b1; adv_pc = 32'h40;
        tick();
        chk_state("R2", 2'd0, 32'h40, 1'b0, 1'b0);
    endtask

    task automatic test_wrong_tid();
        do_miss(2'd2, 32'h77);
        chk_state("R4", 2'd0, 32'h40, 1'b0, 1'b0);
    endtask

    task automatic test_switch();
        do_miss(2'd0, 32'h44);
        chk_state("R3", 2'd0, 32'h44, 1'b1, 1'b1);
        // stimulus during the penalty must be ignored (R4, R2)
        miss_valid = 1'b1; miss_tid = 2'd0; miss_pc = 32'h999;
        adv_valid = 1'b1; adv_pc = 32'h888;
        tick();
        chk_state("R3", 2'd0, 32'h44, 1'b1, 1'b0);
        tick();
        chk_state("R3", 2'd0, 32'h44, 1'b1, 1'b0);
        tick();
        chk_state("R5", 2'd1, 32'h100, 1'b0, 1'b0);
    endtask

    task automatic test_rr_chain();
        do_miss(2'd1, 32'h104);
        repeat (3) tick();
        chk_state("R5", 2'd2, 32'h200, 1'b0, 1'b0);
        ret_valid = 1'b1; ret_tid = 2'd0;
        tick();
        do_miss(2'd2, 32'h208);
        repeat (3) tick();
        chk_state("R5", 2'd3, 32'h300, 1'b0, 1'b0);
        do_miss(2'd3, 32'h30c);
        repeat (3) tick();
        // thread 0 returned earlier: resumes at its missing PC, not 0x999/0x888
        chk_state("R6", 2'd0, 32'h44, 1'b0, 1'b0);
    endtask

    task automatic test_same_cycle_ret();
        do_miss(2'd0, 32'h50);
        tick();
        tick();
        ret_valid = 1'b1; ret_tid = 2'd2;
        tick();
        chk_state("R8", 2'd2, 32'h208, 1'b0, 1'b0);
    endtask

    task automatic test_none_ready();
        do_miss(2'd2, 32'h20c);
        repeat (3) tick();
        chk_state("R7", 2'd2, 32'h20c, 1'b1, 1'b0);
        repeat (5) tick();
        chk_state("R7", 2'd2, 32'h20c, 1'b1, 1'b0);
        ret_valid = 1'b1; ret_tid = 2'd3;
        tick();
        chk_state("R7", 2'd3, 32'h30c, 1'b0, 1'b0);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        test_reset();
        test_adv();
        test_wrong_tid();
        test_switch();
        test_rr_chain();
        test_same_cycle_ret();
        test_none_ready();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule